// File: doc/BRIEF.md
# PCM Highway Frame Sequencer

This block produces the timing for a shared time-division voice highway. Driven by the highway bit clock, it walks through a frame of `NUM_CH` eight-bit channel slots. At the start of each slot it raises that channel's private frame-pulse line for a single bit clock, which tells the attached codec to begin its eight-bit exchange. One extra signaling bit time follows the last slot, and then the frame starts again at channel 0.

The default of 24 channels gives a 193-bit frame. At a 1.544 MHz bit clock that is one frame every 125 µs, or 8000 frames per second. The block also reports where it is in the frame: the current channel number, the bit position inside the slot, a flag that is high during the signaling bit, and a strobe that marks the start of each frame. Carrying the data, filling the signaling bit and generating the clock are the job of other blocks.

Top module: `pcm_frame_seq`

## Requirements
- R1: Consecutive frame-start strobes are exactly 8*NUM_CH+1 bit clocks apart (193 for the default of 24).
- R2: Channel k's pulse line `frame_pulse[k]` is high for exactly one clock, at frame position 8*k, which is bit 0 of slot k. It is low at every other position.
- R3: At most one bit of `frame_pulse` is high in any cycle.
- R4: `sig_bit` is high only at frame position 8*NUM_CH, the last clock of the frame. No frame-pulse line is high in that cycle.
- R5: The clock after the signaling bit is bit 0 of channel 0, with the channel-0 pulse and the frame-start strobe both high.
- R6: Inside a slot, `chan_idx` gives the slot number and `bit_idx` gives the bit position 0..7, counting up by one each clock. During the signaling bit both read 0.
- R7: `frame_start` is high exactly when `frame_pulse[0]` is high.
- R8: While `rst_n` is low, every output is 0; this takes effect at once, with no clock needed. After `rst_n` rises, all outputs stay 0 until the third rising clock edge. Directly after that edge, the frame begins at channel 0 bit 0 with the channel-0 pulse high.
- R9: The channel count is set by the parameter `NUM_CH`, with a default of 24, and the sequence above holds for any count down to 1. Slots are always 8 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | output | NUM_CH | One frame-pulse line per channel |
| chan_idx | output | max(1,clog2(NUM_CH)) | Current channel slot |
| bit_idx | output | 3 | Bit position inside the slot |
| sig_bit | output | 1 | High during the signaling bit time |
| frame_start | output | 1 | Start-of-frame strobe |

## Verification
The bench builds the sequence from a plain frame-position counter and compares every output on every clock. It does this for the default 24-channel build and for a single-channel build, where the last slot is also the first. The corner cases are these:
- At the wrap from the last slot into the signaling bit, a design that skipped the extra bit would give a 192-bit frame.
- At the wrap from the signaling bit back to channel 0, a design that kept counting would pulse a nonexistent channel, or pulse nothing in that cycle.
- At the release from reset, an off-by-one there would move the first pulse by a clock.
- When reset is asserted in the middle of a frame, a design with a synchronous clear would keep its pulses running for a cycle.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
  localparam int SLOT_BITS = 8;
  localparam int BIT_W     = $clog2(SLOT_BITS);

  function automatic int chan_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pcm_slot_counter.sv
module pcm_slot_counter
  import pcm_seq_pkg::*;
#(
  parameter int NUM_CH = 24,
  localparam int CW = chan_width(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_int_n,
  output logic             run_o,
  output logic [CW-1:0]    chan_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             sig_o
);
  localparam logic [CW-1:0]    LAST_CH  = CW'(NUM_CH - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

  logic             run_q, run_d;
  logic [CW-1:0]    chan_q, chan_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             sig_q, sig_d;
  logic             adv_en;

  assign adv_en = run_q;

  always_comb begin
    run_d  = 1'b1;
    chan_d = chan_q;
    bit_d  = bit_q;
    sig_d  = sig_q;
    if (adv_en) begin
      if (sig_q) begin
        sig_d  = 1'b0;
        chan_d = '0;
        bit_d  = '0;
      end else if (bit_q == LAST_BIT) begin
        bit_d = '0;
        if (chan_q == LAST_CH) begin
          sig_d  = 1'b1;
          chan_d = '0;
        end else begin
          chan_d = chan_q + 1'b1;
        end
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q  <= 1'b0;
      chan_q <= '0;
      bit_q  <= '0;
      sig_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      if (adv_en) begin
        chan_q <= chan_d;
        bit_q  <= bit_d;
        sig_q  <= sig_d;
      end
    end
  end

  assign run_o  = run_q;
  assign chan_o = chan_q;
  assign bit_o  = bit_q;
  assign sig_o  = sig_q;

  // R6
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (run_q && !sig_q && bit_q != LAST_BIT) |=> (bit_q == $past(bit_q) + 1'b1 && chan_q == $past(chan_q)));

  // R6
  chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (run_q && !sig_q && bit_q == LAST_BIT && chan_q != LAST_CH) |=> (bit_q == '0 && chan_q == $past(chan_q) + 1'b1));

  // R4
  sig_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (run_q && !sig_q && bit_q == LAST_BIT && chan_q == LAST_CH) |=> sig_q);
endmodule

// File: rtl/pcm_pulse_decode.sv
module pcm_pulse_decode
  import pcm_seq_pkg::*;
#(
  parameter int NUM_CH = 24,
  localparam int CW = chan_width(NUM_CH)
) (
  input  logic              run_i,
  input  logic [CW-1:0]     chan_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              sig_i,
  output logic [NUM_CH-1:0] pulse_o,
  output logic              start_o
);
  logic slot_head;

  assign slot_head = run_i && !sig_i && (bit_i == '0);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_line
    assign pulse_o[k] = slot_head && (chan_i == CW'(k));
  end

  assign start_o = slot_head && (chan_i == '0);
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
  import pcm_seq_pkg::*;
#(
  parameter int NUM_CH = 24,
  localparam int CW = chan_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [NUM_CH-1:0] frame_pulse,
  output logic [CW-1:0]     chan_idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              sig_bit,
  output logic              frame_start
);
  logic rst_int_n;
  logic run;

  pcm_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pcm_slot_counter #(.NUM_CH(NUM_CH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n),
    .run_o     (run),
    .chan_o    (chan_idx),
    .bit_o     (bit_idx),
    .sig_o     (sig_bit)
  );

  pcm_pulse_decode #(.NUM_CH(NUM_CH)) u_dec (
    .run_i   (run),
    .chan_i  (chan_idx),
    .bit_i   (bit_idx),
    .sig_i   (sig_bit),
    .pulse_o (frame_pulse),
    .start_o (frame_start)
  );

  // R3
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    $onehot0(frame_pulse));

  // R4
  sig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    sig_bit |-> (frame_pulse == '0));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    sig_bit |=> (!sig_bit && chan_idx == '0 && bit_idx == '0 && frame_start && frame_pulse[0]));

  // R7
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    frame_start == frame_pulse[0]);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (frame_pulse != '0) |=> (frame_pulse == '0));
endmodule

// File: tb/sim_pcm_frame_seq.sv
module sim_pcm_frame_seq;
  localparam int N0 = 24;
  localparam int N1 = 1;

  logic clk;
  logic rst_n;

  logic [N0-1:0] fp0;
  logic [4:0]    ch0;
  logic [2:0]    bi0;
  logic          sg0, fs0;

  logic [N1-1:0] fp1;
  logic [0:0]    ch1;
  logic [2:0]    bi1;
  logic          sg1, fs1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  pcm_frame_seq #(.NUM_CH(N0)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_pulse(fp0), .chan_idx(ch0),
    .bit_idx(bi0), .sig_bit(sg0), .frame_start(fs0));

  pcm_frame_seq #(.NUM_CH(N1)) u1 (
    .clk(clk), .rst_n(rst_n), .frame_pulse(fp1), .chan_idx(ch1),
    .bit_idx(bi1), .sig_bit(sg1), .frame_start(fs1));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference: edges since release, running flag, frame position
  int  edges = 0;
  bit  run_m = 0;
  int  pos0 = 0, pos1 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges <= 0; run_m <= 0; pos0 <= 0; pos1 <= 0;
    end else if (!run_m) begin
      edges <= edges + 1;
      if (edges + 1 == 3) begin
        run_m <= 1; pos0 <= 0; pos1 <= 0;
      end
    end else begin
      pos0 <= (pos0 + 1) % (8 * N0 + 1);
      pos1 <= (pos1 + 1) % (8 * N1 + 1);
    end
  end

  task automatic cmp(string tag, string who, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, who, act, exp, cyc);
    end
  endtask

  task automatic check_dut(string who, int n, int pos, bit run,
                           logic [31:0] fp, int ch, int bi, logic sg, logic fs);
    logic [31:0] e_fp;
    int e_ch, e_bi;
    bit e_sg, e_fs;
    e_fp = '0; e_ch = 0; e_bi = 0; e_sg = 0; e_fs = 0;
    if (run) begin
      if (pos == 8 * n) e_sg = 1;
      else begin
        e_ch = pos / 8;
        e_bi = pos % 8;
        if (e_bi == 0) e_fp = 32'd1 << e_ch;
        e_fs = (pos == 0);
      end
    end
    if (!run) begin
      cmp("R8", who, int'(fp), 0);
      cmp("R8", who, ch + bi + int'(sg) + int'(fs), 0);
    end else begin
      cmp("R2", who, int'(fp), int'(e_fp));
      cmp("R3", who, (fp & (fp - 1)) == 0, 1);
      cmp("R4", who, int'(sg), int'(e_sg));
      cmp((pos == 0) ? "R5" : "R6", who, ch, e_ch);
      cmp("R6", who, bi, e_bi);
      cmp("R7", who, int'(fs), int'(e_fs));
    end
  endtask

  int last0 = -1, last1 = -1;

  always @(negedge clk) begin
    cyc++;
    check_dut("u0", N0, pos0, run_m, {8'b0, fp0}, int'(ch0), int'(bi0), sg0, fs0);
    check_dut("u1 R9 single-channel", N1, pos1, run_m, {31'b0, fp1}, int'(ch1), int'(bi1), sg1, fs1);
    if (!rst_n) begin
      last0 = -1; last1 = -1;
    end else begin
      if (fs0) begin
        if (last0 >= 0) cmp("R1", "u0 frame period", cyc - last0, 8 * N0 + 1);
        last0 = cyc;
      end
      if (fs1) begin
        if (last1 >= 0) cmp("R1", "u1 R9 frame period", cyc - last1, 8 * N1 + 1);
        last1 = cyc;
      end
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (193 * 4 + 57) @(posedge clk);
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (193 * 3 + 5) @(posedge clk);
    @(negedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule